// File: doc/BRIEF.md
# Timer Interrupt Flag and Request Logic

This block keeps the interrupt state of a 16-bit timer that has three compare/capture channels and one overflow source. The counter and the channel datapath sit elsewhere. They send single-cycle event strobes to this block: a compare match per channel, a capture per channel, terminal count reached, and turnaround at zero. The block decides from the counting mode and the direction of each channel which strobe sets which flag. It keeps four sticky flags that software clears by writing ones.

From the flags, the per-source masks and a global enable, the block drives two things. One is a level that says some enabled source is pending. The other is a one-cycle request pulse to the CPU. A request is raised again when a mask is turned on while its flag is already set. Separately, every compare match on a channel in compare direction produces a one-cycle DMA trigger for that channel. These triggers do not depend on the masks.

Top module: `timer_irq_flags`

## Requirements
- R1: In free-running (`cntMode`=00) or modulo (01) mode, channel n's flag sets on `cmpEvt[n]` when `chCapture[n]`=0 (compare) and on `capEvt[n]` when `chCapture[n]`=1 (capture). The other strobe of that channel is ignored.
- R2: In free-running or modulo mode, the overflow flag sets on `termEvt` and `zeroEvt` is ignored. The code 11 behaves exactly like free-running.
- R3: In up/down mode (`cntMode`=10), the overflow flag sets on `zeroEvt` and `termEvt` is ignored.
- R4: In up/down mode, channel 0 in compare direction sets its flag on `zeroEvt` and ignores `cmpEvt[0]`. Channels 1 and 2 in compare direction set on their compare strobes. Any channel in capture direction sets on its capture strobe.
- R5: A flag appears on the outputs in the cycle after its setting strobe and stays set. When `clrWe`=1, each one in `clrData` clears a flag: bit n clears channel n and bit 3 clears overflow. If a set and a clear hit the same flag in one cycle, the set wins.
- R6: `cpuFlag` is high in any cycle in which at least one flag is set together with its mask bit (`chMask[n]` or `ovfMask`). The masks act combinationally.
- R7: `irqReq` is high for exactly one cycle when some source goes from not masked-pending to masked-pending and `globalEn`=1. This covers a flag setting while its mask is on, and a mask being turned on while its flag is set. `irqReq` is never high while `globalEn`=0.
- R8: `dmaTrig[n]` pulses for one cycle, one cycle after `cmpEvt[n]` is seen with `chCapture[n]`=0. This holds in every mode and does not depend on masks or flags. Compare strobes on capture channels and capture strobes give no trigger.
- R9: After reset all flags, `cpuFlag`, `irqReq` and `dmaTrig` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntMode | input | 2 | Counting mode: 00 free, 01 modulo, 10 up/down, 11 as free |
| chCapture | input | 3 | Per-channel direction, 1 = capture, 0 = compare |
| cmpEvt | input | 3 | Per-channel compare match strobe |
| capEvt | input | 3 | Per-channel capture strobe |
| termEvt | input | 1 | Counter reached terminal count |
| zeroEvt | input | 1 | Counter turned around at zero |
| chMask | input | 3 | Per-channel interrupt mask |
| ovfMask | input | 1 | Overflow interrupt mask |
| globalEn | input | 1 | Global timer interrupt enable |
| clrWe | input | 1 | Write-one-to-clear strobe |
| clrData | input | 4 | Clear bits: [2:0] channels, [3] overflow |
| chFlag | output | 3 | Channel flags |
| ovfFlag | output | 1 | Overflow flag |
| cpuFlag | output | 1 | Some masked source pending |
| irqReq | output | 1 | One-cycle interrupt request pulse |
| dmaTrig | output | 3 | One-cycle DMA trigger per channel |

## Verification
A wrong routing decision or a flag that was lost shows up on `chFlag`/`ovfFlag` one cycle after the strobe. A wrong remembered pending state shows up as a missing or extra `irqReq` pulse in the same cycle as the mask or flag change. The bench runs a model of the flags and of the previous pending vector, and compares every output in every cycle. Mistakes therefore surface within one cycle of the stimulus that exposes them. Directed cases cover the up/down channel 0 redirection, a set and a clear in the same cycle, and a mask turned on while its flag is pending.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NCH = 3;
  localparam int NSRC = NCH + 1;

  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_MOD  = 2'b01,
    MODE_UPDN = 2'b10,
    MODE_RSV  = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic [NCH-1:0] setCh;
    logic           setOvf;
    logic [NCH-1:0] dmaPulse;
  } evt_strobe_t;
endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  cnt_mode_e      mode,
  input  logic [NCH-1:0] chCapture,
  input  logic [NCH-1:0] cmpEvt,
  input  logic [NCH-1:0] capEvt,
  input  logic           termEvt,
  input  logic           zeroEvt,
  output evt_strobe_t    st
);
  logic           isUpDn;
  logic [NCH-1:0] setChW;
  logic           setOvfW;
  logic [NCH-1:0] dmaW;

  assign isUpDn = (mode == MODE_UPDN);

  for (genvar i = 0; i < NCH; i++) begin : g_route
    logic chEvt;
    assign chEvt = chCapture[i] ? capEvt[i] : cmpEvt[i];
    if (i == 0) begin : g_ch0
      assign setChW[i] = (isUpDn && !chCapture[i]) ? zeroEvt : chEvt;
    end else begin : g_chn
      assign setChW[i] = chEvt;
    end
  end

  assign setOvfW = isUpDn ? zeroEvt : termEvt;
  assign dmaW    = cmpEvt & ~chCapture;
  assign st      = '{setCh: setChW, setOvf: setOvfW, dmaPulse: dmaW};

  AST_UD_CH0_NO_CMP: assert property (@(posedge clk) disable iff (!rstN)
    (isUpDn && !chCapture[0] && cmpEvt[0] && !zeroEvt) |-> !st.setCh[0]); // R4
  AST_UD_TERM_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (isUpDn && termEvt && !zeroEvt) |-> !st.setOvf); // R3
  AST_FREE_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!isUpDn && zeroEvt && !termEvt) |-> !st.setOvf); // R2
endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  evt_strobe_t     st,
  input  logic            clrWe,
  input  logic [NSRC-1:0] clrData,
  input  logic [NSRC-1:0] maskVec,
  input  logic            globalEn,
  output logic [NSRC-1:0] flags,
  output logic            cpuFlag,
  output logic            irqReq,
  output logic [NCH-1:0]  dmaTrig
);
  logic [NSRC-1:0] setVec;
  logic [NSRC-1:0] clrVec;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] pendPrev;

  assign setVec = {st.setOvf, st.setCh};
  assign clrVec = clrWe ? clrData : '0;
  assign pend   = flags & maskVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags    <= '0;
      pendPrev <= '0;
      dmaTrig  <= '0;
    end else begin
      flags    <= (flags & ~clrVec) | setVec;
      pendPrev <= pend;
      dmaTrig  <= st.dmaPulse;
    end
  end

  assign cpuFlag = |pend;
  assign irqReq  = globalEn & |(pend & ~pendPrev);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> flags[i]); // R5
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !clrVec[i]) |=> flags[i]); // R5
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rstN)
      (clrVec[i] && !setVec[i]) |=> !flags[i]); // R5
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (globalEn && cpuFlag)); // R7
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import tmr_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     cntMode,
  input  logic [NCH-1:0] chCapture,
  input  logic [NCH-1:0] cmpEvt,
  input  logic [NCH-1:0] capEvt,
  input  logic           termEvt,
  input  logic           zeroEvt,
  input  logic [NCH-1:0] chMask,
  input  logic           ovfMask,
  input  logic           globalEn,
  input  logic           clrWe,
  input  logic [NSRC-1:0] clrData,
  output logic [NCH-1:0] chFlag,
  output logic           ovfFlag,
  output logic           cpuFlag,
  output logic           irqReq,
  output logic [NCH-1:0] dmaTrig
);
  evt_strobe_t     strobes;
  logic [NSRC-1:0] flagsW;

  tmr_irq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (cnt_mode_e'(cntMode)),
    .chCapture (chCapture),
    .cmpEvt    (cmpEvt),
    .capEvt    (capEvt),
    .termEvt   (termEvt),
    .zeroEvt   (zeroEvt),
    .st        (strobes)
  );

  tmr_irq_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .clrWe    (clrWe),
    .clrData  (clrData),
    .maskVec  ({ovfMask, chMask}),
    .globalEn (globalEn),
    .flags    (flagsW),
    .cpuFlag  (cpuFlag),
    .irqReq   (irqReq),
    .dmaTrig  (dmaTrig)
  );

  assign chFlag  = flagsW[NCH-1:0];
  assign ovfFlag = flagsW[NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_dmachk
    AST_DMA_FROM_CMP: assert property (@(posedge clk) disable iff (!rstN)
      dmaTrig[i] |-> $past(cmpEvt[i] && !chCapture[i])); // R8
  end
endmodule

// File: tb/timer_irq_flags_tb.sv
`timescale 1ns/1ps
module timer_irq_flags_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cntMode = '0;
  logic [2:0] chCapture = '0, cmpEvt = '0, capEvt = '0, chMask = '0;
  logic       termEvt = 1'b0, zeroEvt = 1'b0, ovfMask = 1'b0, globalEn = 1'b0, clrWe = 1'b0;
  logic [3:0] clrData = '0;
  logic [2:0] chFlag, dmaTrig;
  logic       ovfFlag, cpuFlag, irqReq;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [3:0] expFlags = '0, expPendPrev = '0;
  logic [2:0] expDma = '0;

  always #2.5 clk = ~clk;

  timer_irq_flags u_dut (
    .clk(clk), .rstN(rstN), .cntMode(cntMode), .chCapture(chCapture),
    .cmpEvt(cmpEvt), .capEvt(capEvt), .termEvt(termEvt), .zeroEvt(zeroEvt),
    .chMask(chMask), .ovfMask(ovfMask), .globalEn(globalEn), .clrWe(clrWe),
    .clrData(clrData), .chFlag(chFlag), .ovfFlag(ovfFlag), .cpuFlag(cpuFlag),
    .irqReq(irqReq), .dmaTrig(dmaTrig)
  );

  // Which sources a set of strobes sets, bit 3 = overflow (R1-R4)
  function automatic logic [3:0] calcSet(logic [1:0] m, logic [2:0] cs, logic [2:0] cm,
                                         logic [2:0] cp, logic te, logic ze);
    logic [3:0] s;
    for (int i = 0; i < 3; i++) s[i] = cs[i] ? cp[i] : cm[i];
    if (m == 2'b10) begin
      s[3] = ze;
      if (!cs[0]) s[0] = ze;
    end else begin
      s[3] = te;
    end
    return s;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Inputs are already driven; compare outputs, then advance model and clock
  task automatic step(string tag);
    logic [3:0] pend;
    logic [3:0] clrV;
    #1;
    pend = expFlags & {ovfMask, chMask};
    check({tag, " flags"}, {4'b0, ovfFlag, chFlag}, {4'b0, expFlags});
    check("R6 cpuFlag", {7'b0, cpuFlag}, {7'b0, |pend});
    check("R7 irqReq", {7'b0, irqReq}, {7'b0, globalEn & |(pend & ~expPendPrev)});
    check("R8 dmaTrig", {5'b0, dmaTrig}, {5'b0, expDma});
    clrV = clrWe ? clrData : 4'b0;
    expFlags = (expFlags & ~clrV) | calcSet(cntMode, chCapture, cmpEvt, capEvt, termEvt, zeroEvt);
    expPendPrev = pend;
    expDma = cmpEvt & ~chCapture;
    @(posedge clk);
    #1;
  endtask

  task automatic setIn(logic [1:0] m, logic [2:0] cs, logic [2:0] cm, logic [2:0] cp,
                       logic te, logic ze, logic cw, logic [3:0] cd, logic [3:0] mk, logic en);
    cntMode = m; chCapture = cs; cmpEvt = cm; capEvt = cp; termEvt = te; zeroEvt = ze;
    clrWe = cw; clrData = cd; chMask = mk[2:0]; ovfMask = mk[3]; globalEn = en;
  endtask

  task automatic idle(logic [1:0] m, logic [2:0] cs, logic [3:0] mk, logic en);
    setIn(m, cs, 3'b0, 3'b0, 1'b0, 1'b0, 1'b0, 4'b0, mk, en);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step("R9");                                         // reset state
    // R1: compare channel 1 and capture channel 2 in free-running mode
    setIn(2'b00, 3'b100, 3'b110, 3'b001, 0, 1, 0, 4'h0, 4'h0, 1); step("R1");
    idle(2'b00, 3'b100, 4'h0, 1); step("R1");
    // R2: code 11 uses terminal count for overflow
    setIn(2'b11, 3'b000, 3'b000, 3'b000, 1, 0, 1, 4'hF, 4'h0, 1); step("R2");
    idle(2'b11, 3'b000, 4'h0, 1); step("R2");
    // R3: up/down ignores terminal count
    setIn(2'b10, 3'b000, 3'b000, 3'b000, 1, 0, 1, 4'hF, 4'h0, 1); step("R3");
    idle(2'b10, 3'b000, 4'h0, 1); step("R3");
    // R4: up/down compare ch0 ignores its compare strobe, then sets on zero
    setIn(2'b10, 3'b000, 3'b111, 3'b000, 0, 0, 0, 4'h0, 4'h0, 1); step("R4");
    idle(2'b10, 3'b000, 4'h0, 1); step("R4");
    setIn(2'b10, 3'b000, 3'b000, 3'b000, 0, 1, 1, 4'hF, 4'h0, 1); step("R4");
    idle(2'b10, 3'b000, 4'h0, 1); step("R4");
    // R5: set and clear on the same flag, set wins
    setIn(2'b00, 3'b000, 3'b001, 3'b000, 0, 0, 1, 4'h7, 4'h0, 1); step("R5");
    idle(2'b00, 3'b000, 4'h0, 1); step("R5");
    // R7: mask turned on while flag pending gives a new pulse
    idle(2'b00, 3'b000, 4'h1, 1); step("R7");
    idle(2'b00, 3'b000, 4'h1, 1); step("R7");
    idle(2'b00, 3'b000, 4'h0, 0); step("R7");
    idle(2'b00, 3'b000, 4'h1, 0); step("R7");
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom();
      setIn(r[1:0], r[4:2], r[7:5] & r[10:8], r[13:11] & r[16:14], r[17] & r[18],
            r[19] & r[20], (r[22:21] == 2'b00), r[26:23], r[30:27], r[31] | r[0]);
      step("R1");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule